// File: doc/BRIEF.md
# Register Access Command Engine

This block turns a stream of received bytes into register accesses and answers each request with a reply byte stream. It sits between the receive side of a UART, which hands over one byte per `rx_valid` pulse, and its transmit side, which takes one byte per `tx_load` pulse and raises `tx_busy` while the byte is being shifted out. A request starts with an opcode byte. A write request carries a register number and a 32-bit value and drives a control-register write port. A read request carries a register number, reads the status-register port and sends the value back.

Each request gets exactly one reply. A reply is an opcode followed by its payload. While a reply is being handed to the UART, the engine does not parse new bytes. Bad opcodes and register numbers outside the implemented range are answered with an error reply that holds a code.

Top module: `regproto_engine`

## Requirements
- R1: After reset, `tx_load` and `ctl_wr_en` are low and no reply byte is sent until a request arrives.
- R2: A write request is the byte 0x01, a register-number byte, then four value bytes, most significant first. When the register number is below NUM_CTL, it produces exactly one `ctl_wr_en` pulse carrying that register number and value.
- R3: An accepted write is answered with the two bytes 0x02, 0x00.
- R4: A read request is the byte 0x03 followed by a register-number byte. When the register number is below NUM_STS, it is answered with 0x04, the register number, then the 32-bit `sts_rd_data` for that number, most significant byte first (six bytes).
- R5: Any first byte other than 0x01 or 0x03 is rejected on that byte alone with the reply 0xEE, 0x01. The byte after that reply is taken as a new opcode.
- R6: A write whose register number is NUM_CTL or greater is answered with 0xEE, 0x02 after all six request bytes have arrived, and it produces no `ctl_wr_en` pulse.
- R7: A read whose register number is NUM_STS or greater is answered with 0xEE, 0x02.
- R8: Each reply byte is handed over as a one-cycle `tx_load` pulse. A pulse is issued only while `tx_busy` is low, and a second pulse is never issued in the cycle right after a load. The UART is assumed to raise `tx_busy` on the clock edge that takes the load.
- R9: Received bytes are dropped from the cycle after the last request byte until the cycle that carries the last reply byte's `tx_load`. A byte arriving in that last-load cycle is accepted as the first byte of a new request.
- R10: Every complete or rejected request yields exactly one reply, with no extra or missing bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte from the UART |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| tx_byte | output | 8 | Reply byte for the UART transmitter |
| tx_load | output | 1 | One-cycle strobe that loads `tx_byte` into the UART |
| tx_busy | input | 1 | UART transmitter is shifting a byte |
| ctl_wr_en | output | 1 | Control-register write strobe |
| ctl_wr_addr | output | 8 | Control-register number being written |
| ctl_wr_data | output | DATA_W | Control-register write value |
| sts_rd_addr | output | 8 | Status-register number being read |
| sts_rd_data | input | DATA_W | Status-register value for `sts_rd_addr` |

## Verification
Two events can fall in the same cycle: the transmit side issues the final `tx_load` of a reply, and the receive side sees a new `rx_valid`. The bench watches for the sixth load of a read reply and drives a bad opcode byte in that very cycle. The byte must be accepted, so an extra 0xEE, 0x01 reply must follow. A second scenario drives a byte during the first load of a reply. That byte must vanish, which the bench judges by counting exactly six reply bytes and then getting a correct reply to a clean read.

// File: rtl/regproto_pkg.sv
// Shared encodings for the register access command engine.
// Assumes one opcode byte starts every request.
package regproto_pkg;
    localparam logic [7:0] OP_WR_REQ   = 8'h01;
    localparam logic [7:0] OP_WR_RSP   = 8'h02;
    localparam logic [7:0] OP_RD_REQ   = 8'h03;
    localparam logic [7:0] OP_RD_RSP   = 8'h04;
    localparam logic [7:0] OP_ERROR    = 8'hEE;
    localparam logic [7:0] CODE_ACK    = 8'h00;
    localparam logic [7:0] CODE_BADOP  = 8'h01;
    localparam logic [7:0] CODE_BADREG = 8'h02;

    typedef enum logic [1:0] {REQ_WRITE, REQ_READ, REQ_BADOP} req_kind_t;
    typedef enum logic [1:0] {PS_OPCODE, PS_REGNUM, PS_VALUE} parse_state_t;
endpackage

// File: rtl/rp_req_parser.sv
// Request parser: collects opcode, register number and value bytes and
// emits one request strobe per complete or rejected request.
// Assumes: while hold is high, incoming bytes are dropped and the request
// fields stay stable for the consumer.
module rp_req_parser
    import regproto_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              hold,
    output logic              req_vld,
    output req_kind_t         req_kind,
    output logic [7:0]        req_reg,
    output logic [DATA_W-1:0] req_data
);
    localparam int NBYTES = DATA_W / 8;
    localparam int CW     = $clog2(NBYTES + 1);

    parse_state_t  st;
    logic [CW-1:0] cnt;

    // Step through the request fields, one byte per accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_OPCODE;
            cnt      <= '0;
            req_vld  <= 1'b0;
            req_kind <= REQ_BADOP;
            req_reg  <= '0;
            req_data <= '0;
        end else begin
            req_vld <= 1'b0;
            if (rx_valid && !hold) begin
                case (st)
                    PS_OPCODE: begin
                        if (rx_byte == OP_WR_REQ) begin
                            req_kind <= REQ_WRITE;
                            st       <= PS_REGNUM;
                        end else if (rx_byte == OP_RD_REQ) begin
                            req_kind <= REQ_READ;
                            st       <= PS_REGNUM;
                        end else begin
                            req_kind <= REQ_BADOP;
                            req_vld  <= 1'b1;
                        end
                    end
                    PS_REGNUM: begin
                        req_reg <= rx_byte;
                        cnt     <= '0;
                        if (req_kind == REQ_READ) begin
                            req_vld <= 1'b1;
                            st      <= PS_OPCODE;
                        end else begin
                            st <= PS_VALUE;
                        end
                    end
                    PS_VALUE: begin
                        req_data <= {req_data[DATA_W-9:0], rx_byte};
                        if (cnt == CW'(NBYTES - 1)) begin
                            req_vld <= 1'b1;
                            st      <= PS_OPCODE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= PS_OPCODE;
                endcase
            end
        end
    end

    // R9: a held byte neither advances the parser nor raises a request.
    p_drop_on_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st) && !req_vld));
endmodule

// File: rtl/rp_reply_ser.sv
// Reply serialiser: takes a framed reply and hands it to the UART one
// byte at a time. Assumes the UART raises tx_busy on the edge that
// takes tx_load, so the cycle after a load is always skipped.
module rp_reply_ser #(
    parameter int MAX_BYTES = 6,
    localparam int LW = $clog2(MAX_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LW-1:0]             start_len,
    input  logic [MAX_BYTES-1:0][7:0] start_frame,
    input  logic                      tx_busy,
    output logic                      active,
    output logic [7:0]                tx_byte,
    output logic                      tx_load
);
    logic [MAX_BYTES-1:0][7:0] frame;
    logic [LW-1:0]             len;
    logic [LW-1:0]             idx;

    // Latch a new reply, then emit one byte whenever the UART is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '0;
            len     <= '0;
            idx     <= '0;
            active  <= 1'b0;
            tx_byte <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (start && !active) begin
                frame  <= start_frame;
                len    <= start_len;
                idx    <= '0;
                active <= 1'b1;
            end else if (active && !tx_busy && !tx_load) begin
                tx_load <= 1'b1;
                tx_byte <= frame[idx];
                idx     <= idx + 1'b1;
                if (idx == len - LW'(1)) begin
                    active <= 1'b0;
                end
            end
        end
    end

    // R8: a load lasts one cycle and never meets a busy transmitter.
    p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
    p_load_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_load) |-> !$past(tx_busy));
    // R10: a new reply never overruns one in flight.
    p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/regproto_engine.sv
// Register access command engine top: parses requests from the UART
// receive stream, performs control writes or status reads, and sends
// one reply per request. Assumes sts_rd_data follows sts_rd_addr
// combinationally.
module regproto_engine
    import regproto_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_CTL = 4,
    parameter int NUM_STS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_load,
    input  logic              tx_busy,
    output logic              ctl_wr_en,
    output logic [7:0]        ctl_wr_addr,
    output logic [DATA_W-1:0] ctl_wr_data,
    output logic [7:0]        sts_rd_addr,
    input  logic [DATA_W-1:0] sts_rd_data
);
    localparam int NB   = DATA_W / 8;
    localparam int MAXB = NB + 2;
    localparam int LW   = $clog2(MAXB + 1);
    localparam logic [7:0] CTL_LIM = 8'(NUM_CTL);
    localparam logic [7:0] STS_LIM = 8'(NUM_STS);

    logic                 req_vld;
    req_kind_t            req_kind;
    logic [7:0]           req_reg;
    logic [DATA_W-1:0]    req_data;
    logic                 ser_active;
    logic                 hold;
    logic                 wr_ok;
    logic [MAXB-1:0][7:0] frame;
    logic [LW-1:0]        flen;

    assign hold        = req_vld || ser_active;
    assign sts_rd_addr = req_reg;
    assign wr_ok       = (req_kind == REQ_WRITE) && (req_reg < CTL_LIM);

    rp_req_parser #(.DATA_W(DATA_W)) i_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .hold     (hold),
        .req_vld  (req_vld),
        .req_kind (req_kind),
        .req_reg  (req_reg),
        .req_data (req_data)
    );

    // Build the reply frame and its length from the decoded request.
    always_comb begin
        frame    = '0;
        flen     = LW'(2);
        frame[0] = OP_ERROR;
        frame[1] = CODE_BADOP;
        case (req_kind)
            REQ_WRITE: begin
                if (req_reg < CTL_LIM) begin
                    frame[0] = OP_WR_RSP;
                    frame[1] = CODE_ACK;
                end else begin
                    frame[1] = CODE_BADREG;
                end
            end
            REQ_READ: begin
                if (req_reg < STS_LIM) begin
                    frame[0] = OP_RD_RSP;
                    frame[1] = req_reg;
                    for (int i = 0; i < NB; i++) begin
                        frame[2+i] = sts_rd_data[DATA_W-1-8*i -: 8];
                    end
                    flen = LW'(MAXB);
                end else begin
                    frame[1] = CODE_BADREG;
                end
            end
            default: ;
        endcase
    end

    // Drive the control-register port for in-range writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_wr_en   <= 1'b0;
            ctl_wr_addr <= '0;
            ctl_wr_data <= '0;
        end else begin
            ctl_wr_en <= req_vld && wr_ok;
            if (req_vld && wr_ok) begin
                ctl_wr_addr <= req_reg;
                ctl_wr_data <= req_data;
            end
        end
    end

    rp_reply_ser #(.MAX_BYTES(MAXB)) i_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_vld),
        .start_len   (flen),
        .start_frame (frame),
        .tx_busy     (tx_busy),
        .active      (ser_active),
        .tx_byte     (tx_byte),
        .tx_load     (tx_load)
    );

    // R6: only in-range control registers are ever written.
    p_ctl_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |-> (ctl_wr_addr < CTL_LIM));
    // R2: a write strobe lasts a single cycle.
    p_ctl_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> !ctl_wr_en);
    // R10: every request starts a reply on the next cycle.
    p_reply_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> ser_active);
endmodule

// File: tb/test_regproto_engine.sv
module test_regproto_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_load;
    logic        tx_busy;
    logic        ctl_wr_en;
    logic [7:0]  ctl_wr_addr;
    logic [31:0] ctl_wr_data;
    logic [7:0]  sts_rd_addr;
    logic [31:0] sts_rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] cap [0:255];
    int ncap = 0;
    int wr_cnt = 0;
    int overlap = 0;
    logic [7:0]  last_addr = '0;
    logic [31:0] last_data = '0;
    int bcnt = 0;

    always #10 clk = ~clk;

    regproto_engine i_regproto_engine (
        .clk (clk), .rst_n (rst_n), .rx_byte (rx_byte), .rx_valid (rx_valid),
        .tx_byte (tx_byte), .tx_load (tx_load), .tx_busy (tx_busy),
        .ctl_wr_en (ctl_wr_en), .ctl_wr_addr (ctl_wr_addr),
        .ctl_wr_data (ctl_wr_data), .sts_rd_addr (sts_rd_addr),
        .sts_rd_data (sts_rd_data)
    );

    function automatic logic [31:0] sts_model(input logic [7:0] a);
        return {a ^ 8'h5A, 8'hC3, ~a, a};
    endfunction
    assign sts_rd_data = sts_model(sts_rd_addr);

    // UART transmitter model: busy from the load edge for four cycles.
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else if (tx_load) bcnt <= 4;
        else if (bcnt != 0) bcnt <= bcnt - 1;
    end
    assign tx_busy = (bcnt != 0);

    // Capture reply bytes and write strobes between edges.
    always @(negedge clk) begin
        if (rst_n && tx_load) begin
            if (tx_busy) overlap++;
            cap[ncap[7:0]] = tx_byte;
            ncap++;
        end
        if (rst_n && ctl_wr_en) begin
            wr_cnt++;
            last_addr = ctl_wr_addr;
            last_data = ctl_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Wait for n reply bytes, then confirm nothing more follows (R10).
    task automatic wait_reply(input int base, input int n);
        for (int k = 0; k < 400 && ncap < base + n; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(ncap == base + n, "R10 reply length", ncap - base, n);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(tx_load == 1'b0, "R1 tx_load after reset", tx_load, 0);
        chk(ctl_wr_en == 1'b0, "R1 ctl_wr_en after reset", ctl_wr_en, 0);
        chk(ncap == 0, "R1 no reply after reset", ncap, 0);
    endtask

    task automatic t_write(input logic [7:0] r, input logic [31:0] v);
        int base = ncap;
        int w0 = wr_cnt;
        send(8'h01); send(r);
        for (int i = 3; i >= 0; i--) send(v[8*i +: 8]);
        wait_reply(base, 2);
        chk(cap[base[7:0]] == 8'h02, "R3 write reply opcode", cap[base[7:0]], 8'h02);
        chk(cap[base[7:0]+1] == 8'h00, "R3 write ack", cap[base[7:0]+1], 8'h00);
        chk(wr_cnt == w0 + 1, "R2 one write strobe", wr_cnt - w0, 1);
        chk(last_addr == r, "R2 write register", last_addr, r);
        chk(last_data == v, "R2 write value msb first", last_data, v);
    endtask

    task automatic t_read(input logic [7:0] r);
        int base = ncap;
        logic [31:0] e = sts_model(r);
        send(8'h03); send(r);
        wait_reply(base, 6);
        chk(cap[base[7:0]] == 8'h04, "R4 read reply opcode", cap[base[7:0]], 8'h04);
        chk(cap[base[7:0]+1] == r, "R4 read echo register", cap[base[7:0]+1], r);
        for (int i = 0; i < 4; i++)
            chk(cap[base[7:0]+8'(2+i)] == e[31-8*i -: 8], "R4 read value byte",
                cap[base[7:0]+8'(2+i)], e[31-8*i -: 8]);
    endtask

    task automatic t_err(input logic [7:0] op, input logic [7:0] r, input bit use_reg,
                         input logic [7:0] code, input string req);
        int base = ncap;
        int w0 = wr_cnt;
        send(op);
        if (use_reg) begin
            send(r);
            if (op == 8'h01) for (int i = 0; i < 4; i++) send(8'h11 * i);
        end
        wait_reply(base, 2);
        chk(cap[base[7:0]] == 8'hEE, req, cap[base[7:0]], 8'hEE);
        chk(cap[base[7:0]+1] == code, req, cap[base[7:0]+1], code);
        chk(wr_cnt == w0, req, wr_cnt - w0, 0);
    endtask

    // R9: a byte arriving during an early reply byte is lost.
    task automatic t_drop();
        int base = ncap;
        send(8'h03); send(8'h01);
        while (ncap < base + 1) @(negedge clk);
        rx_byte = 8'h7F; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        wait_reply(base, 6);
        chk(ncap == base + 6, "R9 byte during reply dropped", ncap - base, 6);
        t_read(8'h02);
    endtask

    // R9: a byte in the cycle of the last load is accepted.
    task automatic t_coincide();
        int base = ncap;
        int loads = 0;
        send(8'h03); send(8'h03);
        while (loads < 6) begin
            @(negedge clk);
            if (tx_load) loads++;
        end
        rx_byte = 8'h7F; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        wait_reply(base, 8);
        chk(cap[base[7:0]+6] == 8'hEE, "R9 byte on last load accepted",
            cap[base[7:0]+6], 8'hEE);
        chk(cap[base[7:0]+7] == 8'h01, "R9 accepted byte parsed as opcode",
            cap[base[7:0]+7], 8'h01);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write(8'h00, 32'hDEADBEEF);
        t_write(8'h03, 32'h01234567);
        t_read(8'h00);
        t_read(8'h04);
        t_err(8'h7F, 8'h00, 1'b0, 8'h01, "R5 unknown opcode");
        t_err(8'h02, 8'h00, 1'b0, 8'h01, "R5 reply opcode as request");
        t_read(8'h01);
        t_err(8'h01, 8'h04, 1'b1, 8'h02, "R6 write out of range");
        t_err(8'h03, 8'h05, 1'b1, 8'h02, "R7 read out of range");
        t_drop();
        t_coincide();
        chk(overlap == 0, "R8 no load while busy", overlap, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule